// File: doc/BRIEF.md
# Network Receive Mailbox with Address Decode

The block sits on a simple processor bus as a small memory-mapped receive mailbox for one incoming network message. The network side writes message words into a data area one word at a time, then commits the message. Committing sets a data-available flag. Software reads the words over the bus and then writes the status word to release the buffer. While the flag is set, the buffer belongs to software. Any further network activity is dropped and recorded in a sticky overrun flag, so an unread message is never overwritten.

The block also decodes the bus address. It steers each access either to itself or to a main-memory window that lies outside this block, and never to both. It holds an interrupt-handler vector word that software writes during start-up. It raises an interrupt request while a message is waiting and interrupts are enabled.

Byte addresses are used throughout, and the low two address bits are ignored. Relative to the device base, the words are laid out as follows:
- Words 0 to 15 hold message data.
- Word 16 is status: bit 0 is data-available, bit 1 is overrun, bit 2 is interrupt enable, and all other bits read as zero.
- Word 17 is the handler vector.

Top module: `net_rx_mmio`

## Requirements
- R1: `dev_sel_o` is high, in the same cycle, exactly for a bus read or write whose address lies in the 18-word window starting at byte address 0xF0000000 (0xF0000000 to 0xF0000047). Word index = (address − base) / 4, and the low two address bits are ignored. `bus_rdata_o` is zero unless `dev_sel_o` and `bus_rd_i` are both high.
- R2: `mem_sel_o` is high, in the same cycle, for a bus read or write whose address is below 0x1000 (1024 words). `mem_sel_o` and `dev_sel_o` are never high together. Any other address selects neither.
- R3: `net_commit_i` with data-available clear sets data-available (status bit 0) from the next cycle on. The bit stays set until a status-word write with bit 0 equal to 0. A status write with bit 0 equal to 1 never sets it.
- R4: A network word write (`net_wr_i`, word index `net_idx_i`) stores `net_data_i` at that data word when data-available is clear before the edge. While data-available is set, the data area does not change.
- R5: A network write or commit that arrives while data-available is set (judged before the edge) is dropped and sets overrun (status bit 1). Overrun stays set until a status write with bit 1 equal to 0. A drop in the same cycle as that write wins.
- R6: A status write loads the interrupt enable (status bit 2) from write data bit 2. A status read returns {0…, enable, overrun, data-available}.
- R7: `irq_o` is high exactly when data-available and interrupt enable are both set.
- R8: Word 17 is loaded with the full write data by a bus write and read back unchanged.
- R9: Bus writes to data words 0 to 15 have no effect on their contents.
- R10: After reset, the status word, the vector word and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 32 | Bus byte address |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Device read data, combinational |
| mem_sel_o | output | 1 | Access is steered to main memory |
| dev_sel_o | output | 1 | Access is steered to this device |
| net_wr_i | input | 1 | Network word write strobe |
| net_idx_i | input | 4 | Network data word index |
| net_data_i | input | 32 | Network word data |
| net_commit_i | input | 1 | Network marks message complete |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-word message area at base 0xF0000000 and a 1024-word memory window. Every decode edge is therefore a fixed address the bench can hit directly. These edges are the last memory word, the first address past memory, the addresses just below and just above the device window, and a misaligned device address. A behavioural reference model is stepped every cycle. It covers same-cycle races between the network side and software: a commit meeting a status clear, a drop meeting an overrun clear, and a commit arriving while the buffer is held.

// File: rtl/net_rx_pkg.sv
package net_rx_pkg;
  typedef struct packed {
    logic en;
    logic ovr;
    logic dav;
  } rx_status_t;
  localparam int unsigned ST_W = $bits(rx_status_t);
endpackage

// File: rtl/net_rx_dec.sv
module net_rx_dec #(
  parameter int unsigned    AW        = 32,
  parameter logic [AW-1:0]  BASE_ADDR = 32'hF000_0000,
  parameter int unsigned    DEV_WORDS = 18,
  parameter int unsigned    MEM_WORDS = 1024,
  parameter int unsigned    OFS_W     = 5
) (
  input  logic [AW-1:0]    addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  output logic             mem_sel_o,
  output logic             dev_sel_o,
  output logic [OFS_W-1:0] ofs_o
);
  localparam logic [AW:0] DEV_LO = {1'b0, BASE_ADDR};
  localparam logic [AW:0] DEV_HI = DEV_LO + (AW+1)'(DEV_WORDS * 4);
  localparam logic [AW:0] MEM_HI = (AW+1)'(MEM_WORDS * 4);

  logic [AW:0]   addr_x;
  logic [AW-1:0] rel;
  logic          acc;

  assign addr_x    = {1'b0, addr_i};
  assign acc       = rd_i | wr_i;
  assign rel       = addr_i - BASE_ADDR;
  assign ofs_o     = rel[OFS_W+1:2];
  assign dev_sel_o = acc && (addr_x >= DEV_LO) && (addr_x < DEV_HI);
  assign mem_sel_o = acc && (addr_x < MEM_HI) && !dev_sel_o;
endmodule

// File: rtl/net_rx_buf.sv
module net_rx_buf #(
  parameter int unsigned DW        = 32,
  parameter int unsigned MSG_WORDS = 16,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned OFS_W     = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [DW-1:0]           data_i,
  input  logic [OFS_W-1:0]        rd_idx_i,
  output logic [DW-1:0]           rd_data_o,
  output logic [MSG_WORDS*DW-1:0] flat_o
);
  logic [DW-1:0] word_q [MSG_WORDS];

  for (genvar g = 0; g < MSG_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              word_q[g] <= '0;
      else if (wr_i && idx_i == IDX_W'(g))      word_q[g] <= data_i;
    end
    assign flat_o[g*DW +: DW] = word_q[g];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < MSG_WORDS; i++)
      if (rd_idx_i == OFS_W'(i)) rd_data_o = word_q[i];
  end
endmodule

// File: rtl/net_rx_ctrl.sv
module net_rx_ctrl
  import net_rx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       net_wr_i,
  input  logic       net_commit_i,
  input  logic       st_wr_i,
  input  logic       vec_wr_i,
  input  logic [DW-1:0] wdata_i,
  output rx_status_t st_o,
  output logic [DW-1:0] vec_o,
  output logic       accept_o
);
  rx_status_t    st_q;
  logic [DW-1:0] vec_q;
  logic          drop, clr_dav, clr_ovr;

  assign accept_o = net_wr_i & ~st_q.dav;
  assign drop     = (net_wr_i | net_commit_i) & st_q.dav;
  assign clr_dav  = st_wr_i & ~wdata_i[0];
  assign clr_ovr  = st_wr_i & ~wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      vec_q <= '0;
    end else begin
      st_q.dav <= (st_q.dav & ~clr_dav) | (net_commit_i & ~st_q.dav);
      st_q.ovr <= (st_q.ovr & ~clr_ovr) | drop;  // drop wins over clear
      if (st_wr_i)  st_q.en <= wdata_i[2];
      if (vec_wr_i) vec_q   <= wdata_i;
    end
  end

  assign st_o  = st_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/net_rx_mmio.sv
module net_rx_mmio
  import net_rx_pkg::*;
#(
  parameter int unsigned   AW        = 32,
  parameter int unsigned   DW        = 32,
  parameter logic [AW-1:0] BASE_ADDR = 32'hF000_0000,
  parameter int unsigned   MEM_WORDS = 1024,
  parameter int unsigned   MSG_WORDS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic             bus_rd_i,
  input  logic             bus_wr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             mem_sel_o,
  output logic             dev_sel_o,
  input  logic             net_wr_i,
  input  logic [$clog2(MSG_WORDS)-1:0] net_idx_i,
  input  logic [DW-1:0]    net_data_i,
  input  logic             net_commit_i,
  output logic             irq_o
);
  localparam int unsigned IDX_W     = $clog2(MSG_WORDS);
  localparam int unsigned DEV_WORDS = MSG_WORDS + 2;
  localparam int unsigned OFS_W     = $clog2(DEV_WORDS);
  localparam logic [OFS_W-1:0] OFS_ST  = OFS_W'(MSG_WORDS);
  localparam logic [OFS_W-1:0] OFS_VEC = OFS_W'(MSG_WORDS + 1);

  logic [OFS_W-1:0]        ofs;
  logic                    st_wr, vec_wr, net_acc;
  logic [DW-1:0]           msg_rd, vec_q;
  logic [MSG_WORDS*DW-1:0] msg_flat;
  rx_status_t              st_q;

  net_rx_dec #(
    .AW(AW), .BASE_ADDR(BASE_ADDR), .DEV_WORDS(DEV_WORDS),
    .MEM_WORDS(MEM_WORDS), .OFS_W(OFS_W)
  ) u_dec (
    .addr_i(bus_addr_i), .rd_i(bus_rd_i), .wr_i(bus_wr_i),
    .mem_sel_o(mem_sel_o), .dev_sel_o(dev_sel_o), .ofs_o(ofs)
  );

  assign st_wr  = dev_sel_o & bus_wr_i & (ofs == OFS_ST);
  assign vec_wr = dev_sel_o & bus_wr_i & (ofs == OFS_VEC);

  net_rx_ctrl #(.DW(DW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .net_wr_i(net_wr_i), .net_commit_i(net_commit_i),
    .st_wr_i(st_wr), .vec_wr_i(vec_wr), .wdata_i(bus_wdata_i),
    .st_o(st_q), .vec_o(vec_q), .accept_o(net_acc)
  );

  net_rx_buf #(
    .DW(DW), .MSG_WORDS(MSG_WORDS), .IDX_W(IDX_W), .OFS_W(OFS_W)
  ) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(net_acc), .idx_i(net_idx_i), .data_i(net_data_i),
    .rd_idx_i(ofs), .rd_data_o(msg_rd), .flat_o(msg_flat)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (dev_sel_o && bus_rd_i) begin
      if (ofs == OFS_ST)       bus_rdata_o = DW'(st_q);
      else if (ofs == OFS_VEC) bus_rdata_o = vec_q;
      else                     bus_rdata_o = msg_rd;
    end
  end

  assign irq_o = st_q.dav & st_q.en;
endmodule

// File: rtl/net_rx_mmio_checks.sv
module net_rx_mmio_checks #(
  parameter int unsigned DW        = 32,
  parameter int unsigned MSG_WORDS = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    net_wr_i,
  input logic                    net_commit_i,
  input logic                    st_wr_i,
  input logic [DW-1:0]           wdata_i,
  input logic                    dav_i,
  input logic                    ovr_i,
  input logic                    en_i,
  input logic                    irq_o,
  input logic                    mem_sel_o,
  input logic                    dev_sel_o,
  input logic [MSG_WORDS*DW-1:0] msg_i
);
  p_sel_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_sel_o && dev_sel_o));

  p_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    net_commit_i && !dav_i |=> dav_i);

  p_dav_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dav_i && !(st_wr_i && !wdata_i[0]) |=> dav_i);

  p_no_overwrite_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dav_i |=> $stable(msg_i));

  p_ovr_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (net_wr_i || net_commit_i) && dav_i |=> ovr_i);

  p_ovr_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i && !(st_wr_i && !wdata_i[1]) |=> ovr_i);

  p_irq_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> dav_i && en_i);
endmodule

bind net_rx_mmio net_rx_mmio_checks #(.DW(DW), .MSG_WORDS(MSG_WORDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .net_wr_i(net_wr_i), .net_commit_i(net_commit_i),
  .st_wr_i(st_wr), .wdata_i(bus_wdata_i),
  .dav_i(st_q.dav), .ovr_i(st_q.ovr), .en_i(st_q.en),
  .irq_o(irq_o), .mem_sel_o(mem_sel_o), .dev_sel_o(dev_sel_o),
  .msg_i(msg_flat)
);

// File: tb/net_rx_mmio_tb_top.sv
module net_rx_mmio_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'hF000_0000;
  localparam logic [31:0] ST_A = BASE + 32'h40;
  localparam logic [31:0] VEC_A = BASE + 32'h44;

  logic clk = 0, rst_n = 0;
  logic [31:0] addr = 0, wdata = 0, net_data = 0;
  logic rd = 0, wr = 0, nwr = 0, ncommit = 0;
  logic [3:0] nidx = 0;
  logic [31:0] rdata;
  logic mem_sel, dev_sel, irq;

  int tests = 0, fails = 0;

  // reference model state
  logic [31:0] m_msg [16];
  logic m_dav = 0, m_ovr = 0, m_en = 0;
  logic [31:0] m_vec = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  net_rx_mmio dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_rd_i(rd),
    .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .mem_sel_o(mem_sel), .dev_sel_o(dev_sel), .net_wr_i(nwr),
    .net_idx_i(nidx), .net_data_i(net_data), .net_commit_i(ncommit),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit in_dev(input logic [31:0] a);
    return a >= BASE && a < BASE + 32'd72;
  endfunction

  // one bus/network cycle; called at negedge, returns at next negedge
  task automatic cyc(input logic [31:0] a, input logic r, input logic w,
                     input logic [31:0] wd, input logic nw, input logic [3:0] ni,
                     input logic [31:0] nd, input logic nc);
    logic acc, ed, em, old_dav, stw, vecw;
    int wi;
    logic [31:0] er;
    addr = a; rd = r; wr = w; wdata = wd;
    nwr = nw; nidx = ni; net_data = nd; ncommit = nc;
    #1;
    acc = r | w;
    ed = acc && in_dev(a);
    em = acc && (a < 32'h1000);
    wi = int'((a - BASE) >> 2);
    er = 0;
    if (ed && r) begin
      if (wi < 16) er = m_msg[wi];
      else if (wi == 16) er = {29'b0, m_en, m_ovr, m_dav};
      else er = m_vec;
    end
    chk("R1 dev_sel", 32'(dev_sel), 32'(ed));
    chk("R2 mem_sel", 32'(mem_sel), 32'(em));
    if (ed && r) chk(wi < 16 ? "R4 data read" : (wi == 16 ? "R6 status read" : "R8 vector read"), rdata, er);
    else chk("R1 rdata idle", rdata, 32'h0);
    chk("R7 irq", 32'(irq), 32'(m_dav && m_en));
    @(posedge clk);
    old_dav = m_dav;
    stw = ed && w && wi == 16;
    vecw = ed && w && wi == 17;
    if (nw && !old_dav) m_msg[ni] = nd;
    m_ovr = (m_ovr && !(stw && !wd[1])) || ((nw || nc) && old_dav);
    m_dav = (old_dav && !(stw && !wd[0])) || (nc && !old_dav);
    if (stw) m_en = wd[2];
    if (vecw) m_vec = wd;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [31:0] a);
    cyc(a, 1, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    cyc(a, 0, 1, d, 0, 0, 0, 0);
  endtask
  task automatic net_word(input logic [3:0] i, input logic [31:0] d);
    cyc(0, 0, 0, 0, 1, i, d, 0);
  endtask

  // independent status check with a fixed expected value
  task automatic st_is(input logic [2:0] exp, input string tag);
    addr = ST_A; rd = 1; wr = 0; nwr = 0; ncommit = 0;
    #1 chk(tag, rdata, {29'b0, exp});
    rd = 0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_msg[i] = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R10: reset state
    st_is(3'b000, "R10 status after reset");
    bus_rd(VEC_A);
    chk("R10 irq after reset", 32'(irq), 0);
    // R1/R2 decode edges
    bus_rd(32'h0); bus_rd(32'hFFC); bus_rd(32'h1000);
    bus_rd(BASE - 4); bus_rd(BASE + 32'h44); bus_rd(BASE + 32'h48);
    bus_rd(BASE + 32'h41); bus_rd(32'h8000_0000);
    bus_wr(32'h10, 32'hDEAD); bus_wr(BASE + 32'h48, 32'h1);
    // R8 vector
    bus_wr(VEC_A, 32'h1234_5678); bus_rd(VEC_A);
    // R6 enable only
    bus_wr(ST_A, 32'h4);
    st_is(3'b100, "R6 enable set");
    // R4 fill message, R3 commit
    for (int i = 0; i < 16; i++) net_word(4'(i), 32'hA000_0000 + 32'(i * 17));
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    st_is(3'b101, "R3 commit sets dav");
    chk("R7 irq raised", 32'(irq), 1);
    for (int i = 0; i < 16; i++) bus_rd(BASE + 32'(i * 4));
    // R5 drop while held
    net_word(4'd5, 32'hBAD0_0005);
    bus_rd(BASE + 32'h14);
    chk("R4 word 5 kept while held", rdata, 32'hA000_0055);
    st_is(3'b111, "R5 overrun set");
    cyc(0, 0, 0, 0, 0, 0, 0, 1);   // commit while held also drops
    // R9 bus write to data ignored
    bus_wr(BASE + 32'hC, 32'hFFFF_FFFF);
    bus_rd(BASE + 32'hC);
    chk("R9 data write ignored", rdata, 32'hA000_0033);
    // clear overrun, keep dav
    bus_wr(ST_A, 32'h5);
    st_is(3'b101, "R5 overrun cleared, R3 dav kept");
    // drop coincides with overrun clear: drop wins
    cyc(ST_A, 0, 1, 32'h5, 1, 4'd1, 32'h0, 0);
    st_is(3'b111, "R5 drop wins over clear");
    // disable irq with dav set
    bus_wr(ST_A, 32'h1);
    chk("R7 irq off when disabled", 32'(irq), 0);
    // release buffer
    bus_wr(ST_A, 32'h4);
    st_is(3'b100, "R3 dav cleared by software");
    // software cannot set dav
    bus_wr(ST_A, 32'h7);
    st_is(3'b100, "R3 write one does not set dav");
    // commit with clear same cycle: commit (dav was clear) wins
    cyc(ST_A, 0, 1, 32'h4, 1, 4'd2, 32'h5555_0002, 1);
    st_is(3'b101, "R3 commit with clear write");
    bus_rd(BASE + 32'h8);
    chk("R4 new word stored", rdata, 32'h5555_0002);
    // clear dav in same cycle as held-buffer write: write still dropped
    cyc(ST_A, 0, 1, 32'h4, 1, 4'd2, 32'h6666_0002, 0);
    st_is(3'b110, "R5 drop judged before edge");
    bus_rd(BASE + 32'h8);
    repeat (3) bus_rd(ST_A);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule